// File: doc/BRIEF.md
# GF(2^8) Polynomial-Basis Multiplier

This block multiplies two 8-bit elements of the binary extension field GF(2^8), with both operands written in polynomial basis. The work is done in two combinational stages. The first forms the carry-less product of the operands. In this product the partial products are combined by XOR, so no carries occur, and the result is a 15-bit polynomial. The second stage reduces that polynomial modulo the fixed irreducible polynomial x^8 + x^4 + x^3 + x + 1, which gives an 8-bit field element.

A single-cycle pulse on `in_valid` presents one operand pair. One clock later the block registers two values: the unreduced 15-bit product and the reduced field element. It flags them with a one-cycle `out_valid` pulse and holds both values until the next capture. The raw product is exposed so that downstream logic can reuse it or perform its own reduction.

Top module: `gf_mul_top`

## Requirements
- R1: `prod_o` equals the carry-less product of the captured `a_i` and `b_i`. Bit k of the product is the XOR, over all i + j = k, of a[i]&b[j], for k = 0..14.
- R2: `res_o` equals `prod_o` reduced modulo x^8+x^4+x^3+x+1. The polynomial's low byte is 8'h1B and its x^8 term is implicit.
- R3: With a = 8'b10101010 and b = 8'b10001111, `prod_o` is 15'b101001100000110 and `res_o` is 8'b00011010.
- R4: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high, and low otherwise.
- R5: While `in_valid` is low, `prod_o` and `res_o` keep their values, whatever `a_i` and `b_i` do.
- R6: If one operand is 8'h01, `res_o` and `prod_o` both equal the other operand.
- R7: If either operand is 8'h00, `prod_o` and `res_o` are both zero.
- R8: Swapping `a_i` and `b_i` gives identical `prod_o` and `res_o`.
- R9: While `rst` is high at a rising clock edge, `out_valid`, `prod_o` and `res_o` are cleared to zero on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Capture strobe for the operands |
| a_i | input | 8 | First operand, polynomial basis |
| b_i | input | 8 | Second operand, polynomial basis |
| out_valid | output | 1 | One-cycle pulse marking a fresh result |
| prod_o | output | 15 | Registered unreduced carry-less product |
| res_o | output | 8 | Registered reduced field element |

## Verification
A fault in the partial-product array shows up as a wrong `prod_o` one cycle after the faulty operand pair is captured. A fault in the fold chain leaves `prod_o` correct but gives a wrong `res_o` in that same cycle. A wrong fold polynomial or a wrong fold order only shows up for products whose upper bits are set. For that reason every one of the 65536 operand pairs is streamed through back to back and each one is checked on the following cycle. A broken capture enable or valid register shows up as drifting outputs or a misplaced pulse within one idle cycle.

// File: rtl/gf_mul_pkg.sv
package gf_mul_pkg;
  localparam int unsigned GF_W = 8;
  localparam int unsigned GF_PW = 2 * GF_W - 1;
  localparam logic [GF_W-1:0] GF_POLY_LOW = 8'h1B;
endpackage

// File: rtl/gf_clmul.sv
module gf_clmul #(
  parameter int unsigned W = 8,
  localparam int unsigned PW = 2 * W - 1
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  output logic [PW-1:0] prod_o
);
  logic [PW-1:0] pp [W];

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_row
      assign pp[gi] = b_i[gi] ? (PW'(a_i) << gi) : '0;
    end
  endgenerate

  always_comb begin
    prod_o = '0;
    for (int i = 0; i < W; i++) begin
      prod_o = prod_o ^ pp[i];
    end
  end
endmodule

// File: rtl/gf_reduce.sv
module gf_reduce #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] POLY = 8'h1B,
  localparam int unsigned PW = 2 * W - 1,
  localparam int unsigned HW = W - 1
) (
  input  logic [PW-1:0] prod_i,
  output logic [W-1:0]  res_o
);
  localparam logic [PW-1:0] POLY_EXT = {{(PW-W-1){1'b0}}, 1'b1, POLY};

  logic [HW-1:0] hi;
  logic [W-1:0]  lo;
  logic [PW-1:0] fold;

  // Highest bit first, so bits set by a fold are cleared later in the chain.
  always_comb begin
    hi   = prod_i[PW-1:W];
    lo   = prod_i[W-1:0];
    fold = '0;
    for (int k = HW - 1; k >= 0; k--) begin
      if (hi[k]) begin
        fold = POLY_EXT << k;
        hi   = hi ^ fold[PW-1:W];
        lo   = lo ^ fold[W-1:0];
      end
    end
    res_o = lo;
  end
endmodule

// File: rtl/gf_mul_top.sv
module gf_mul_top
  import gf_mul_pkg::*;
#(
  parameter int unsigned W = GF_W,
  parameter logic [W-1:0] POLY = GF_POLY_LOW,
  localparam int unsigned PW = 2 * W - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  output logic          out_valid,
  output logic [PW-1:0] prod_o,
  output logic [W-1:0]  res_o
);
  logic [PW-1:0] prod_c;
  logic [W-1:0]  res_c;

  gf_clmul #(.W(W)) u_clmul (
    .a_i    (a_i),
    .b_i    (b_i),
    .prod_o (prod_c)
  );

  gf_reduce #(.W(W), .POLY(POLY)) u_reduce (
    .prod_i (prod_c),
    .res_o  (res_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      prod_o    <= '0;
      res_o     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        prod_o <= prod_c;
        res_o  <= res_c;
      end
    end
  end
endmodule

// File: rtl/gf_mul_checker.sv
module gf_mul_checker #(
  parameter int unsigned W = 8,
  localparam int unsigned PW = 2 * W - 1
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [W-1:0]  a_i,
  input logic [W-1:0]  b_i,
  input logic          out_valid,
  input logic [PW-1:0] prod_o,
  input logic [W-1:0]  res_o
);
  assert_valid_follows_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(prod_o) && $stable(res_o)));

  assert_zero_operand_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (a_i == '0 || b_i == '0)) |=> (prod_o == '0 && res_o == '0));

  assert_identity_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && b_i == W'(1)) |=> (res_o == $past(a_i)));

  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> (!out_valid && prod_o == '0 && res_o == '0));
endmodule

bind gf_mul_top gf_mul_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .a_i       (a_i),
  .b_i       (b_i),
  .out_valid (out_valid),
  .prod_o    (prod_o),
  .res_o     (res_o)
);

// File: tb/tb_gf_mul_top.sv
module tb_gf_mul_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int PW = 2 * W - 1;
  localparam int WATCHDOG = 190000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [W-1:0]  a_i = '0;
  logic [W-1:0]  b_i = '0;
  logic          out_valid;
  logic [PW-1:0] prod_o;
  logic [W-1:0]  res_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  gf_mul_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a_i(a_i), .b_i(b_i),
    .out_valid(out_valid), .prod_o(prod_o), .res_o(res_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference product: bit-serial shift-and-XOR over b.
  function automatic logic [PW-1:0] ref_clmul(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [PW-1:0] p = '0;
    for (int i = 0; i < W; i++) if (y[i]) p = p ^ (PW'(x) << i);
    return p;
  endfunction

  // Reference field product: repeated doubling with reduction at each step.
  function automatic logic [W-1:0] ref_fmul(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] acc = '0;
    logic [W-1:0] t = x;
    for (int i = 0; i < W; i++) begin
      if (y[i]) acc = acc ^ t;
      t = t[W-1] ? ((t << 1) ^ 8'h1B) : (t << 1);
    end
    return acc;
  endfunction

  task automatic check15(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check8(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // One isolated operation: drive, then sample one cycle later, then idle.
  task automatic one_op(input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    a_i = x; b_i = y; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
        finish_run();
      end
    end
  end

  initial begin
    logic [W-1:0] pa, pb;
    repeat (3) @(negedge clk);
    // R9: reset state
    check1("R9 out_valid after reset", out_valid, 1'b0);
    check15("R9 prod after reset", prod_o, '0);
    check8("R9 res after reset", res_o, '0);
    rst = 1'b0;

    // R3: worked example
    one_op(8'b10101010, 8'b10001111);
    check15("R3 prod", prod_o, 15'b101001100000110);
    check8("R3 res", res_o, 8'b00011010);
    check1("R4 valid after capture", out_valid, 1'b1);
    @(negedge clk);
    check1("R4 valid single pulse", out_valid, 1'b0);

    // R5: inputs change while idle, outputs hold
    a_i = 8'h5C; b_i = 8'hE3;
    @(negedge clk);
    check15("R5 prod hold", prod_o, 15'b101001100000110);
    check8("R5 res hold", res_o, 8'b00011010);

    // R6: identity on either side
    one_op(8'hC7, 8'h01);
    check8("R6 res b=1", res_o, 8'hC7);
    check15("R6 prod b=1", prod_o, 15'h00C7);
    one_op(8'h01, 8'h3E);
    check8("R6 res a=1", res_o, 8'h3E);
    check15("R6 prod a=1", prod_o, 15'h003E);

    // R7: zero operand
    one_op(8'hFF, 8'h00);
    check15("R7 prod b=0", prod_o, '0);
    check8("R7 res b=0", res_o, '0);
    one_op(8'h00, 8'hB9);
    check15("R7 prod a=0", prod_o, '0);
    check8("R7 res a=0", res_o, '0);

    // R8: swapped pair gives identical outputs
    one_op(8'hD4, 8'h9B);
    pa = res_o;
    one_op(8'h9B, 8'hD4);
    check8("R8 swap res", res_o, pa);
    check15("R8 swap prod", prod_o, ref_clmul(8'hD4, 8'h9B));

    // R1, R2, R4, R8: exhaustive back-to-back sweep
    pa = '0; pb = '0;
    for (int i = 0; i < 65536; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check15("R1 sweep prod", prod_o, ref_clmul(pa, pb));
        check8("R2/R8 sweep res", res_o, ref_fmul(pb, pa));
        if (out_valid !== 1'b1) check1("R4 sweep valid", out_valid, 1'b1);
      end
      pa = W'(i >> 8);
      pb = W'(i);
      a_i = pa; b_i = pb; in_valid = 1'b1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    check15("R1 sweep last prod", prod_o, ref_clmul(pa, pb));
    check8("R2 sweep last res", res_o, ref_fmul(pa, pb));
    a_i = 8'h11; b_i = 8'h22;
    @(negedge clk);
    check1("R4 valid drops after sweep", out_valid, 1'b0);
    check15("R5 hold after sweep", prod_o, ref_clmul(8'hFF, 8'hFF));

    // R9: reset mid-run clears results
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check15("R9 prod cleared", prod_o, '0);
    check8("R9 res cleared", res_o, '0);
    check1("R9 valid cleared", out_valid, 1'b0);

    finish_run();
  end
endmodule